// File: doc/BRIEF.md
# Delay Tap Sweep Calibration Controller

This block picks a read-capture delay for a DDR memory interface. On a start request it walks a 6-bit delay tap through every value from 0 to 63. For each value it drives the same tap onto all four byte-lane delay outputs and lets the delay lines settle. It then runs the memory self-test engine until that engine reports completion. It reads the engine's status word to decide whether the tap worked.

It remembers how many taps passed, the first passing tap and the most recent passing tap. Once the sweep ends it drives the truncated midpoint of the first and last passing taps onto all lanes. If nothing passed, it drives a fixed fallback tap instead. A one-cycle done pulse then marks the end of calibration, and the chosen tap stays on the lanes until the next start.

Top module: `tap_sweep_cal`

## Requirements
- R1: One calibration makes exactly 64 self-test trials, with taps 0, 1, 2, ... 63 in that order.
- R2: All four lane tap outputs carry the same value at all times. `laneTaps` holds lane k in bits [6k+5:6k].
- R3: The tap on the lanes has been stable for at least one cycle before the self-test enable rises, and it stays stable while the enable is high.
- R4: The self-test enable stays high until bit 0 of the status word reads 1. The enable is low in the following cycle.
- R5: A trial passes only when the fail field, status bits [16:9], is zero and the pass field, status bits [8:1], equals `runCount`. A zero fail field with a short pass count is a failure, and so is a matching pass count with a non-zero fail field.
- R6: When at least one tap passed, the final tap is (first passing tap + last passing tap) >> 1, truncated. Failing taps between the two passing taps do not change the result.
- R7: When no tap passed, the final tap is 8.
- R8: `done` is high for exactly one cycle, and the final tap is already on the lanes in that cycle. The lanes keep the final tap afterwards.
- R9: A start request that arrives while a calibration is under way has no effect.
- R10: After reset, `done` and `bistEn` are low and all lane taps are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration (ignored while one is running) |
| done | output | 1 | One-cycle pulse when the final tap is applied |
| laneTaps | output | 24 | Four 6-bit lane delay taps, lane 0 in the low bits |
| bistEn | output | 1 | Self-test enable; high runs a trial, low stops it |
| bistStatus | input | 17 | Self-test status: bit 0 complete, [8:1] pass runs, [16:9] fail runs |
| runCount | input | 8 | Configured number of self-test runs per trial |

## Verification
The responder passes a chosen window of taps, and each window shape isolates one case. A wide interior window checks the midpoint. A window of the full range checks truncation of an odd sum. A window of only the last tap, or only the first, checks that the edges of the sweep are counted, and a two-tap window checks rounding down. A window with a short-count tap at its front edge, a window with a hole in the middle, and a single short-count tap with no real passes separate the zero-fail and exact-count halves of the pass rule. They also show that the pass count does not depend on taps being contiguous. An empty window selects the fallback tap, and a second start sent mid-sweep must leave the trial count and the result unchanged.

// File: rtl/tap_cal_pkg.sv
package tap_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETTLE, ST_RUN, ST_EVAL, ST_FINAL, ST_DONE
  } calState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;   // restart sweep at tap 0
    logic capture;  // latch self-test result fields
    logic record;   // score the latched result for current tap
    logic step;     // advance to next tap
    logic loadFinal;// apply chosen tap
  } calCtrl_t;
endpackage

// File: rtl/tap_cal_ctrl.sv
module tap_cal_ctrl
  import tap_cal_pkg::*;
#(
  parameter int SETTLE_CYC = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     statDone,
  input  logic     lastTap,
  output calCtrl_t ctrl,
  output logic     bistEn,
  output logic     done
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  calState_t state, stateNext;
  logic [CW-1:0] settleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_SETTLE) settleCnt <= settleCnt + 1'b1;
      else                    settleCnt <= '0;
    end
  end

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        ctrl.clrAll = 1'b1;
        stateNext   = ST_SETTLE;
      end
      ST_SETTLE: if (settleCnt == CW'(SETTLE_CYC - 1)) stateNext = ST_RUN;
      ST_RUN: if (statDone) begin
        ctrl.capture = 1'b1;
        stateNext    = ST_EVAL;
      end
      ST_EVAL: begin
        ctrl.record = 1'b1;
        if (lastTap) stateNext = ST_FINAL;
        else begin
          ctrl.step = 1'b1;
          stateNext = ST_SETTLE;
        end
      end
      ST_FINAL: begin
        ctrl.loadFinal = 1'b1;
        stateNext      = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign bistEn = (state == ST_RUN);
  assign done   = (state == ST_DONE);
endmodule

// File: rtl/tap_cal_dp.sv
module tap_cal_dp
  import tap_cal_pkg::*;
#(
  parameter int          TAP_W       = 6,
  parameter int          LANES       = 4,
  parameter int          CNT_W       = 8,
  parameter int          DEFAULT_TAP = 8,
  parameter logic [31:0] SENTINEL    = 32'hAA55_AA55
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  calCtrl_t               ctrl,
  input  logic [2*CNT_W-1:0]     statFields,
  input  logic [CNT_W-1:0]       runCount,
  output logic                   lastTap,
  output logic [LANES*TAP_W-1:0] laneTaps
);
  localparam logic [TAP_W-1:0] TAP_MAX = '1;

  logic [TAP_W-1:0] tapReg, laneReg, finalTap;
  logic [TAP_W:0]   passCnt;
  logic [31:0]      firstPass;
  logic [TAP_W-1:0] lastPass;
  logic [CNT_W-1:0] passRuns, failRuns;
  logic             passOk;
  logic [TAP_W:0]   winSum;

  assign passOk  = (failRuns == '0) && (passRuns == runCount);
  assign lastTap = (tapReg == TAP_MAX);
  assign winSum  = {1'b0, firstPass[TAP_W-1:0]} + {1'b0, lastPass};
  assign finalTap = (passCnt == '0) ? TAP_W'(DEFAULT_TAP) : winSum[TAP_W:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapReg    <= '0;
      laneReg   <= '0;
      passCnt   <= '0;
      firstPass <= SENTINEL;
      lastPass  <= '0;
      passRuns  <= '0;
      failRuns  <= '0;
    end else begin
      if (ctrl.clrAll) begin
        tapReg    <= '0;
        laneReg   <= '0;
        passCnt   <= '0;
        firstPass <= SENTINEL;
        lastPass  <= '0;
      end
      if (ctrl.capture) begin
        passRuns <= statFields[CNT_W-1:0];
        failRuns <= statFields[2*CNT_W-1:CNT_W];
      end
      if (ctrl.record && passOk) begin
        passCnt  <= passCnt + 1'b1;
        lastPass <= tapReg;
        if (firstPass == SENTINEL) firstPass <= {{(32-TAP_W){1'b0}}, tapReg};
      end
      if (ctrl.step) begin
        tapReg  <= tapReg + 1'b1;
        laneReg <= tapReg + 1'b1;
      end
      if (ctrl.loadFinal) laneReg <= finalTap;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneTaps[g*TAP_W +: TAP_W] = laneReg;
  end
endmodule

// File: rtl/tap_sweep_cal.sv
module tap_sweep_cal
  import tap_cal_pkg::*;
#(
  parameter int TAP_W       = 6,
  parameter int LANES       = 4,
  parameter int CNT_W       = 8,
  parameter int SETTLE_CYC  = 2,
  parameter int DEFAULT_TAP = 8,
  localparam int STAT_W     = 1 + 2*CNT_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  output logic                   done,
  output logic [LANES*TAP_W-1:0] laneTaps,
  output logic                   bistEn,
  input  logic [STAT_W-1:0]      bistStatus,
  input  logic [CNT_W-1:0]       runCount
);
  calCtrl_t ctrl;
  logic     lastTap;

  tap_cal_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .statDone(bistStatus[0]),
    .lastTap(lastTap), .ctrl(ctrl), .bistEn(bistEn), .done(done)
  );

  tap_cal_dp #(.TAP_W(TAP_W), .LANES(LANES), .CNT_W(CNT_W),
               .DEFAULT_TAP(DEFAULT_TAP)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .statFields(bistStatus[STAT_W-1:1]),
    .runCount(runCount), .lastTap(lastTap), .laneTaps(laneTaps)
  );
endmodule

// File: rtl/tap_sweep_cal_chk.sv
module tap_sweep_cal_chk #(
  parameter int TAP_W  = 6,
  parameter int LANES  = 4,
  parameter int STAT_W = 17
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   done,
  input logic                   bistEn,
  input logic [STAT_W-1:0]      bistStatus,
  input logic [LANES*TAP_W-1:0] laneTaps
);
  logic [TAP_W-1:0] lane0;
  assign lane0 = laneTaps[TAP_W-1:0];

  for (genvar g = 1; g < LANES; g++) begin : g_eq
    AST_LANES_EQUAL: assert property (@(posedge clk) disable iff (!rstN)
      laneTaps[g*TAP_W +: TAP_W] == lane0); // R2
  end

  AST_SETTLED_BEFORE_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bistEn) |-> lane0 == $past(lane0)); // R3

  AST_STABLE_WHILE_EN: assert property (@(posedge clk) disable iff (!rstN)
    bistEn |=> $stable(lane0)); // R3

  AST_EN_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (bistEn && bistStatus[0]) |=> !bistEn); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    done |=> $stable(lane0)); // R8

  AST_DONE_IDLE_EN: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !bistEn); // R8
endmodule

bind tap_sweep_cal tap_sweep_cal_chk #(.TAP_W(TAP_W), .LANES(LANES), .STAT_W(STAT_W))
  u_chk (.clk(clk), .rstN(rstN), .done(done), .bistEn(bistEn),
         .bistStatus(bistStatus), .laneTaps(laneTaps));

// File: tb/tap_sweep_cal_test.sv
module tap_sweep_cal_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        done, bistEn;
  logic [23:0] laneTaps;
  logic [16:0] bistStatus;
  logic [7:0]  runCount = 8'd8;

  int checkCnt = 0, failCnt = 0, cycles = 0;
  int winLo = 1, winHi = 0, shortTap = 255;
  int trialCnt = 0, seqErr = 0;
  logic prevEn = 1'b0;
  int lat = 0;

  always #10 clk = ~clk;

  tap_sweep_cal uut (.clk(clk), .rstN(rstN), .start(start), .done(done),
    .laneTaps(laneTaps), .bistEn(bistEn), .bistStatus(bistStatus), .runCount(runCount));

  // self-test responder: passes taps in [winLo,winHi]; shortTap gives a short count with no fails
  always @(posedge clk) begin
    prevEn <= bistEn;
    if (bistEn && !prevEn) begin
      if (int'(laneTaps[5:0]) != trialCnt) seqErr <= seqErr + 1;
      trialCnt <= trialCnt + 1;
    end
    if (!bistEn) begin
      bistStatus <= '0;
      lat <= 0;
    end else if (lat == 3) begin
      int t;
      t = int'(laneTaps[5:0]);
      if (t == shortTap)                bistStatus <= {8'd0, runCount - 8'd1, 1'b1};
      else if (t >= winLo && t <= winHi) bistStatus <= {8'd0, runCount, 1'b1};
      else                               bistStatus <= {8'd1, runCount, 1'b1};
    end else lat <= lat + 1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failCnt = failCnt + 1;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic lanes_chk(input string req, input int exp);
    for (int k = 0; k < 4; k++) chk(req, int'(laneTaps[k*6 +: 6]), exp);
  endtask

  // lo, hi, shortTap, runs, expected final tap
  localparam int NV = 9;
  localparam int VEC [NV][5] = '{
    '{10, 20, 255,   8, 15},  // R6 interior window
    '{ 0, 63, 255,   8, 31},  // R6 full range, odd sum truncated
    '{63, 63, 255,   8, 63},  // R1 last tap counted
    '{ 0,  0, 255, 200,  0},  // R1 first tap counted
    '{ 5,  6, 255,   8,  5},  // R6 rounds down
    '{ 1,  0, 255,   8,  8},  // R7 nothing passes
    '{10, 20,  10,   8, 15},  // R5 short count at window edge
    '{30, 40,  35,   8, 35},  // R6 hole in window
    '{20, 20,  20,  50,  8}   // R5 only a short-count tap
  };

  task automatic run_cal(input int lo, input int hi, input int sh, input int runs,
                         input int exp, input bit midStart);
    int w;
    winLo = lo; winHi = hi; shortTap = sh; runCount = 8'(runs);
    trialCnt = 0; seqErr = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    w = 0;
    while (!done && w < 3000) begin
      @(negedge clk);
      w++;
      if (midStart && w == 100) start = 1'b1;
      if (midStart && w == 101) start = 1'b0;
    end
    chk("R8 done seen", int'(done), 1);
    lanes_chk("R6/R7/R5 final tap", exp);
    chk("R1 trial count", trialCnt, 64);
    chk("R1 tap order errors", seqErr, 0);
    @(negedge clk);
    chk("R8 done one cycle", int'(done), 0);
    lanes_chk("R8 final tap held", exp);
    repeat (3) @(negedge clk);
    lanes_chk("R8 final tap held later", exp);
    chk("R9 no restart", int'(bistEn), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 done after reset", int'(done), 0);
    chk("R10 bistEn after reset", int'(bistEn), 0);
    lanes_chk("R10 lanes after reset", 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++)
      run_cal(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], 1'b0);
    // R9: second start mid-sweep must not restart or extend the sweep
    run_cal(12, 16, 255, 8, 14, 1'b1);
    // R2 lanes all equal mid-sweep
    winLo = 1; winHi = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (57) @(negedge clk);
    for (int k = 1; k < 4; k++)
      chk("R2 lanes equal", int'(laneTaps[k*6 +: 6]), int'(laneTaps[5:0]));
    while (!done) @(negedge clk);
    lanes_chk("R7 fallback after R2 run", 8);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule